// File: doc/BRIEF.md
# Power Port Event and Interrupt Register Bank

This block keeps the event status and interrupt masking for one power port. Two monitored status inputs, power-good and power-enable, are watched for transitions. Any transition, in either direction, latches a sticky bit in an event register. An 8-bit mask register then decides which of the latched conditions may pull the active-low interrupt output.

Software reaches the bank over a simple synchronous register bus with an address, a write strobe, a read strobe, write data and registered read data. The event register appears at two addresses. One gives a plain view that leaves the register untouched. The other returns the same contents and empties the register in the same step. A third address exposes a summary interrupt register that shows the latched conditions whatever the mask holds.

Top module: `pwr_irq_bank`

## Requirements
- R1: A synchronous reset sets the mask register to A4h and the event register to 00h, drives read data to 00h and leaves the interrupt output high. No event is recorded for the input levels present when reset is released.
- R2: A write at address 01h stores the write data in the mask register, with bit 6 always stored as 0. A read at 01h returns the mask register.
- R3: Either edge of power-good sets event bit 4, and either edge of power-enable sets event bit 0. Each set takes effect at the clock edge that first samples the new input level. All other event bits read as 0. A set bit stays 1 when its input returns to its earlier level or holds steady.
- R4: A read at address 02h returns the event register and leaves it unchanged.
- R5: A read at address 03h returns the event register as it was before the read and clears it to 00h at the same clock edge.
- R6: When an edge is sampled at the same clock edge as a read at 03h, the read returns the old contents and the bit for that edge is 1 afterwards.
- R7: A read at address 00h returns the interrupt register. Its bit 1 equals event bit 4, its bit 0 equals event bit 0 and its other bits are 0. The mask has no effect on it.
- R8: The interrupt output is low exactly when (interrupt bit 1 AND mask bit 1) OR (interrupt bit 0 AND mask bit 0) is 1. A masked condition is still recorded in the event and interrupt registers.
- R9: Writes to any address other than 01h change neither the mask register nor the event register.
- R10: Read data is registered at the clock edge that samples the read strobe and holds its value while no read is made. A read at an unmapped address returns 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pgood_i | input | 1 | Power-good status, synchronous to clk |
| pwren_i | input | 1 | Power-enable status, synchronous to clk |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The edge capture is tried with rising and falling transitions on each monitored input, with an input that holds a level after a clear, and with an edge that lands in the same cycle as a clear-on-read. Together these separate edge latching from level following and show whether an event survives the clear. The interrupt output is tried under the reset mask, an all-enabled mask, an all-clear mask and a mask that enables a single source, so that a swapped or ignored mask bit shows up. Plain reads, clearing reads, writes to read-only and unmapped addresses, and an idle bus are interleaved, and a reference model is compared with the outputs on every clock.

// File: rtl/pwr_irq_pkg.sv
package pwr_irq_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 8;

    // monitored sources, index into the source vector
    localparam int N_SRC    = 2;
    localparam int SRC_PWEN = 0;
    localparam int SRC_PG   = 1;

    // bit positions of the sources in the event byte and in the interrupt byte
    localparam int EVT_POS_PWEN  = 0;
    localparam int EVT_POS_PG    = 4;
    localparam int INTR_POS_PWEN = 0;
    localparam int INTR_POS_PG   = 1;

    localparam logic [REG_AW-1:0] ADR_INTR    = 8'h00;
    localparam logic [REG_AW-1:0] ADR_MASK    = 8'h01;
    localparam logic [REG_AW-1:0] ADR_EVT     = 8'h02;
    localparam logic [REG_AW-1:0] ADR_EVT_COR = 8'h03;

    localparam logic [REG_DW-1:0] MASK_RST  = 8'hA4;
    localparam logic [REG_DW-1:0] MASK_WMSK = 8'hBF;   // bit 6 reserved

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_INTR,
        SEL_MASK,
        SEL_EVT,
        SEL_EVT_COR
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(logic [REG_AW-1:0] a);
        reg_sel_e s;
        case (a)
            ADR_INTR:    s = SEL_INTR;
            ADR_MASK:    s = SEL_MASK;
            ADR_EVT:     s = SEL_EVT;
            ADR_EVT_COR: s = SEL_EVT_COR;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [REG_DW-1:0] pack_event(logic [N_SRC-1:0] ev);
        logic [REG_DW-1:0] b;
        b = '0;
        b[EVT_POS_PG]   = ev[SRC_PG];
        b[EVT_POS_PWEN] = ev[SRC_PWEN];
        return b;
    endfunction

    function automatic logic [REG_DW-1:0] pack_intr(logic [N_SRC-1:0] ev);
        logic [REG_DW-1:0] b;
        b = '0;
        b[INTR_POS_PG]   = ev[SRC_PG];
        b[INTR_POS_PWEN] = ev[SRC_PWEN];
        return b;
    endfunction

endpackage

// File: rtl/pwr_irq_edge.sv
module pwr_irq_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] edge_o
);
    logic [N-1:0] last_q;

    // the last sample follows the input during reset too, so the level
    // present at reset release is not taken as an edge
    always_ff @(posedge clk) begin
        last_q <= sig_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign edge_o[i] = !rst && (sig_i[i] != last_q[i]);
    end

endmodule

// File: rtl/pwr_irq_evreg.sv
module pwr_irq_evreg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] ev_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // a set in the clearing cycle wins over the clear
        always_ff @(posedge clk) begin
            if (rst) ev_q[i] <= 1'b0;
            else     ev_q[i] <= (ev_q[i] & ~clr_i) | set_i[i];
        end

        AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> ev_q[i]);                                  // R6
        AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ev_q[i] && !clr_i) |=> ev_q[i]);                       // R3
        AST_COR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
            (clr_i && !set_i[i]) |=> !ev_q[i]);                     // R5
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
            (!ev_q[i] && !set_i[i]) |=> !ev_q[i]);                  // R4
    end

endmodule

// File: rtl/pwr_irq_regs.sv
module pwr_irq_regs
    import pwr_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    input  logic [REG_DW-1:0] wdata_i,
    input  logic [N_SRC-1:0]  ev_i,
    output logic [REG_DW-1:0] mask_o,
    output logic [REG_DW-1:0] rdata_o,
    output logic              clr_o
);
    logic [REG_DW-1:0] mask_q;
    logic [REG_DW-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= MASK_RST;
        else if (req_i.wr && req_i.sel == SEL_MASK)
            mask_q <= wdata_i & MASK_WMSK;
    end

    always_comb begin
        case (req_i.sel)
            SEL_INTR:    rd_mux = pack_intr(ev_i);
            SEL_MASK:    rd_mux = mask_q;
            SEL_EVT:     rd_mux = pack_event(ev_i);
            SEL_EVT_COR: rd_mux = pack_event(ev_i);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            rdata_o <= '0;
        else if (req_i.rd)  rdata_o <= rd_mux;
    end

    assign clr_o  = req_i.rd && (req_i.sel == SEL_EVT_COR);
    assign mask_o = mask_q;

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr && req_i.sel == SEL_MASK) |=> (mask_q == ($past(wdata_i) & MASK_WMSK))); // R2
    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(req_i.wr && req_i.sel == SEL_MASK) |=> $stable(mask_q));  // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_i.rd |=> $stable(rdata_o));                            // R10

endmodule

// File: rtl/pwr_irq_gen.sv
module pwr_irq_gen
    import pwr_irq_pkg::*;
(
    input  logic [REG_DW-1:0] intr_i,
    input  logic [REG_DW-1:0] mask_i,
    output logic              irq_n_o
);
    assign irq_n_o = ~|(intr_i & mask_i);
endmodule

// File: rtl/pwr_irq_bank.sv
module pwr_irq_bank
    import pwr_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_DW-1:0] bus_wdata,
    output logic [REG_DW-1:0] bus_rdata,
    input  logic              pgood_i,
    input  logic              pwren_i,
    output logic              irq_n
);
    bus_req_t          req;
    logic [N_SRC-1:0]  src;
    logic [N_SRC-1:0]  edges;
    logic [N_SRC-1:0]  ev;
    logic              clr;
    logic [REG_DW-1:0] mask;

    assign req.rd  = bus_rd;
    assign req.wr  = bus_wr;
    assign req.sel = decode_addr(bus_addr);

    assign src[SRC_PG]   = pgood_i;
    assign src[SRC_PWEN] = pwren_i;

    pwr_irq_edge #(.N(N_SRC)) u_edge (
        .clk(clk), .rst(rst), .sig_i(src), .edge_o(edges)
    );

    pwr_irq_evreg #(.N(N_SRC)) u_evreg (
        .clk(clk), .rst(rst), .set_i(edges), .clr_i(clr), .ev_q(ev)
    );

    pwr_irq_regs u_regs (
        .clk(clk), .rst(rst), .req_i(req), .wdata_i(bus_wdata),
        .ev_i(ev), .mask_o(mask), .rdata_o(bus_rdata), .clr_o(clr)
    );

    pwr_irq_gen u_gen (
        .intr_i(pack_intr(ev)), .mask_i(mask), .irq_n_o(irq_n)
    );

    AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (|ev));                                          // R8
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask[1:0] == 2'b00) |-> irq_n);                            // R8
    AST_RSVD_MASK_BIT: assert property (@(posedge clk) disable iff (rst)
        !mask[6]);                                                  // R2

endmodule

// File: tb/pwr_irq_bank_tb_top.sv
module pwr_irq_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = 8'h00;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pg = 1'b0;
    logic       pw = 1'b0;
    logic       irq_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_irq_bank dut_i (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .pgood_i(pg), .pwren_i(pw),
        .irq_n(irq_n)
    );

    // behavioural reference model
    logic [7:0] m_mask, m_ev, m_rdata;
    logic       m_pg, m_pw;
    bit         m_valid = 0;

    always @(posedge clk) begin
        logic [7:0] v;
        logic [7:0] nev;
        if (rst) begin
            m_mask = 8'hA4; m_ev = 8'h00; m_rdata = 8'h00;
            m_pg = pg; m_pw = pw; m_valid = 1;
        end else begin
            case (addr)
                8'h00:        v = {6'b0, m_ev[4], m_ev[0]};
                8'h01:        v = m_mask;
                8'h02, 8'h03: v = m_ev;
                default:      v = 8'h00;
            endcase
            if (rd) m_rdata = v;
            if (wr && addr == 8'h01) m_mask = wdata & 8'hBF;
            nev = (rd && addr == 8'h03) ? 8'h00 : m_ev;
            if (pg != m_pg) nev = nev | 8'h10;
            if (pw != m_pw) nev = nev | 8'h01;
            m_ev = nev;
            m_pg = pg; m_pw = pw;
        end
    end

    function automatic logic model_irq_n();
        return !((m_ev[4] & m_mask[1]) | (m_ev[0] & m_mask[0]));
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (m_valid && !done) begin
            check("R10 per-cycle read data", rdata, m_rdata);
            check("R8 per-cycle interrupt", {7'b0, irq_n}, {7'b0, model_irq_n()});
        end
    end

    task automatic bus_read(logic [7:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic toggle_pg();
        @(negedge clk); pg = ~pg;
        @(negedge clk);
    endtask

    task automatic toggle_pw();
        @(negedge clk); pw = ~pw;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        pg = 1'b1;                       // high level across reset: no event
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 read data after reset", rdata, 8'h00);
        check("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
        bus_read(8'h01, v); check("R1 mask reset value", v, 8'hA4);
        bus_read(8'h02, v); check("R1 event reset value", v, 8'h00);

        bus_write(8'h01, 8'hFF);
        bus_read(8'h01, v); check("R2 mask write with bit 6 reserved", v, 8'hBF);

        toggle_pg();                     // falling edge of power-good
        check("R8 unmasked event drives irq low", {7'b0, irq_n}, 8'h00);
        bus_read(8'h02, v); check("R3 pg edge sets bit 4", v, 8'h10);
        bus_read(8'h02, v); check("R4 plain read leaves contents", v, 8'h10);
        bus_read(8'h00, v); check("R7 interrupt register bit 1", v, 8'h02);
        bus_read(8'h03, v); check("R5 clearing read returns contents", v, 8'h10);
        bus_read(8'h02, v); check("R5 register cleared", v, 8'h00);
        check("R8 irq released after clear", {7'b0, irq_n}, 8'h01);

        repeat (3) @(negedge clk);       // steady level: nothing new
        bus_read(8'h02, v); check("R3 steady level records nothing", v, 8'h00);

        toggle_pg();                     // rising edge
        toggle_pw();
        toggle_pw();                     // back to old level, bit stays
        bus_read(8'h02, v); check("R3 both edges latched", v, 8'h11);
        bus_read(8'h00, v); check("R7 interrupt register both bits", v, 8'h03);
        bus_read(8'h03, v); check("R5 clearing read both bits", v, 8'h11);

        bus_write(8'h01, 8'h00);
        bus_read(8'h01, v); check("R2 mask cleared", v, 8'h00);
        toggle_pw();
        check("R8 masked event keeps irq high", {7'b0, irq_n}, 8'h01);
        bus_read(8'h02, v); check("R8 masked event still recorded", v, 8'h01);
        bus_read(8'h00, v); check("R7 interrupt register ignores mask", v, 8'h01);

        bus_write(8'h00, 8'hFF);
        bus_write(8'h02, 8'hFF);
        bus_write(8'h03, 8'h00);
        bus_write(8'h09, 8'hFF);
        bus_read(8'h02, v); check("R9 event unchanged by writes", v, 8'h01);
        bus_read(8'h01, v); check("R9 mask unchanged by writes", v, 8'h00);
        bus_read(8'h03, v); check("R5 clear before race", v, 8'h01);

        bus_write(8'h01, 8'h02);         // power-good source only
        toggle_pw();
        check("R8 pwen source masked", {7'b0, irq_n}, 8'h01);
        bus_read(8'h03, v); check("R5 clear pwen event", v, 8'h01);

        // edge in the same cycle as a clearing read
        @(negedge clk); pg = ~pg; addr = 8'h03; rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
        check("R6 race read returns old contents", v, 8'h00);
        check("R6 race edge drives irq", {7'b0, irq_n}, 8'h00);
        bus_read(8'h02, v); check("R6 race edge survives clear", v, 8'h10);

        bus_read(8'h07, v); check("R10 unmapped address", v, 8'h00);
        bus_read(8'h01, v); check("R2 mask readback", v, 8'h02);
        repeat (3) @(negedge clk);
        check("R10 read data holds while idle", rdata, 8'h02);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule